// File: doc/BRIEF.md
# Code-Selected Dual-Read Register File

This block is a small general-purpose register file for an accumulator-style datapath whose instruction word carries device-select codes rather than explicit register numbers. Three codes arrive each cycle: a 3-bit source code for the left operand bus, a 4-bit source code for the right operand bus and a 5-bit destination code. The register file answers to the lowest codes of each field. A code whose bits above the register-address field are all zero names a register, and the low bits of that code are the register index. Any other code belongs to some other device on the bus, and the file stays off that bus.

Each read port is purely combinational. It presents the addressed register together with a drive flag. When the port is not selected, it drives zeros and lowers the flag, which matches a bus that is pulled down when nothing drives it. Writes take effect only on the rising clock edge while the execute-phase qualifier is high, so a destination code that settles during fetch or decode can never corrupt a register. A debug read port returns any register by index so that a test can inspect the stored state.

Top module: `dcode_regfile`

## Requirements
- R1: An active-low reset (`rst_n` = 0) clears every register to zero.
- R2: On a rising `clk` edge with `exec_phase` = 1 and `t_code` in 0..3 (bits 4:2 all zero), register `t_code[1:0]` takes `wr_data`, and the other registers keep their values.
- R3: On a rising `clk` edge with `exec_phase` = 0, no register changes, whatever the destination code is.
- R4: On a rising `clk` edge with `t_code` of 4 or more (any of bits 4:2 set), no register changes, even with `exec_phase` = 1.
- R5: The left port is enabled exactly when bit 2 of `a_code` is 0. It then sets `l_drive` = 1 and presents register `a_code[1:0]` on `l_data`.
- R6: The right port is enabled exactly when bits 3 and 2 of `b_code` are both 0. It then sets `r_drive` = 1 and presents register `b_code[1:0]` on `r_data`.
- R7: A disabled read port sets its drive flag to 0 and its data to zero.
- R8: A read of the register being written in the same cycle returns the old value until the clock edge, and returns the new value after the edge.
- R9: `dbg_data` always shows the current contents of register `dbg_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes occur on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_phase | input | 1 | High during the execute phase; qualifies writes |
| a_code | input | 3 | Left-bus source device code |
| b_code | input | 4 | Right-bus source device code |
| t_code | input | 5 | Destination device code |
| wr_data | input | 8 | Data to be written |
| l_data | output | 8 | Left read port data (zero when disabled) |
| l_drive | output | 1 | Left read port is driving its bus |
| r_data | output | 8 | Right read port data (zero when disabled) |
| r_drive | output | 1 | Right read port is driving its bus |
| dbg_idx | input | 2 | Register index for the debug port |
| dbg_data | output | 8 | Contents of register `dbg_idx` |

## Verification
The assertions check the following on every cycle:
- both enable decodes against the raw code bits;
- the zero value on a disabled port;
- that the addressed register holds the written byte after a qualified write;
- that the whole file is frozen after an edge where `exec_phase` is low or the destination is a non-register device;
- the debug port against the stored contents.

Only the bench's scenarios can show the following:
- that each port returns the right register's value;
- that a read in the same cycle as a write to the same register sees the old value;
- that reset clears state written beforehand.

The bench shows these by comparing against its own model while constrained random codes are mixed with directed edge codes.

// File: rtl/rfd_pkg.sv
package rfd_pkg;
  // Architecture-fixed widths of the device-select fields
  localparam int A_CODE_W = 3;
  localparam int B_CODE_W = 4;
  localparam int T_CODE_W = 5;

  // A device code names a register when every bit above the index field is zero
  function automatic logic names_register(input logic [7:0] code, input int code_w, input int idx_w);
    logic hit;
    hit = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (i >= idx_w && i < code_w && code[i]) hit = 1'b0;
    end
    return hit;
  endfunction
endpackage

// File: rtl/rfd_tdec.sv
module rfd_tdec #(
  parameter int NREG = 4,
  parameter int TW   = 5,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            exec_phase,
  input  logic [TW-1:0]   t_code,
  output logic [NREG-1:0] tsel_n,
  output logic            fire,
  output logic [AW-1:0]   idx
);
  // Active-low per-register destination selects
  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      tsel_n[i] = !(t_code == TW'(i));
    end
  end

  // A write fires only when some register select is low and the execute phase is on
  assign fire = exec_phase && !(&tsel_n);
  assign idx  = t_code[AW-1:0];
endmodule

// File: rtl/rfd_store.sv
module rfd_store #(
  parameter int DW   = 8,
  parameter int NREG = 4,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [AW-1:0]            widx,
  input  logic [DW-1:0]            wdata,
  output logic [NREG-1:0][DW-1:0]  view
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        view[g] <= '0;
      end else if (we && widx == AW'(g)) begin
        view[g] <= wdata;
      end
    end
  end
endmodule

// File: rtl/rfd_rport.sv
module rfd_rport #(
  parameter int DW   = 8,
  parameter int NREG = 4,
  parameter int CW   = 3,
  localparam int AW  = $clog2(NREG)
) (
  input  logic [CW-1:0]            code,
  input  logic [NREG-1:0][DW-1:0]  view,
  output logic [DW-1:0]            data,
  output logic                     drive
);
  logic          en_n;
  logic [AW-1:0] ridx;

  // The enable is active low and comes from the bits above the index field
  assign en_n  = |code[CW-1:AW];
  assign ridx  = code[AW-1:0];
  assign drive = !en_n;
  // A released bus reads as zero
  assign data  = en_n ? '0 : view[ridx];
endmodule

// File: rtl/dcode_regfile.sv
module dcode_regfile #(
  parameter int DW   = 8,
  parameter int NREG = 4,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       exec_phase,
  input  logic [rfd_pkg::A_CODE_W-1:0] a_code,
  input  logic [rfd_pkg::B_CODE_W-1:0] b_code,
  input  logic [rfd_pkg::T_CODE_W-1:0] t_code,
  input  logic [DW-1:0]              wr_data,
  output logic [DW-1:0]              l_data,
  output logic                       l_drive,
  output logic [DW-1:0]              r_data,
  output logic                       r_drive,
  input  logic [AW-1:0]              dbg_idx,
  output logic [DW-1:0]              dbg_data
);
  // Named internal events, visible to the bound checker
  logic [NREG-1:0]          tsel_n;
  logic                     wr_fire;
  logic [AW-1:0]            wr_idx;
  logic [NREG-1:0][DW-1:0]  file_view;

  rfd_tdec #(.NREG(NREG), .TW(rfd_pkg::T_CODE_W)) u_tdec (
    .exec_phase (exec_phase),
    .t_code     (t_code),
    .tsel_n     (tsel_n),
    .fire       (wr_fire),
    .idx        (wr_idx)
  );

  rfd_store #(.DW(DW), .NREG(NREG)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_fire),
    .widx  (wr_idx),
    .wdata (wr_data),
    .view  (file_view)
  );

  rfd_rport #(.DW(DW), .NREG(NREG), .CW(rfd_pkg::A_CODE_W)) u_left (
    .code  (a_code),
    .view  (file_view),
    .data  (l_data),
    .drive (l_drive)
  );

  rfd_rport #(.DW(DW), .NREG(NREG), .CW(rfd_pkg::B_CODE_W)) u_right (
    .code  (b_code),
    .view  (file_view),
    .data  (r_data),
    .drive (r_drive)
  );

  assign dbg_data = file_view[dbg_idx];
endmodule

// File: rtl/rfd_checker.sv
module rfd_checker #(
  parameter int DW   = 8,
  parameter int NREG = 4,
  localparam int AW  = $clog2(NREG)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      exec_phase,
  input logic [2:0]                a_code,
  input logic [3:0]                b_code,
  input logic [4:0]                t_code,
  input logic [DW-1:0]             wr_data,
  input logic [DW-1:0]             l_data,
  input logic                      l_drive,
  input logic [DW-1:0]             r_data,
  input logic                      r_drive,
  input logic [AW-1:0]             dbg_idx,
  input logic [DW-1:0]             dbg_data,
  input logic [NREG-1:0][DW-1:0]   file_view
);
  logic t_is_reg;
  assign t_is_reg = (t_code[4:AW] == '0);

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_phase && t_is_reg) |=> file_view[$past(t_code[AW-1:0])] == $past(wr_data)); // R2
  AST_IDLE_PHASE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_phase |=> file_view == $past(file_view)); // R3
  AST_FOREIGN_TARGET_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !t_is_reg |=> file_view == $past(file_view)); // R4
  AST_LEFT_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    l_drive == !a_code[2]); // R5
  AST_RIGHT_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    r_drive == (b_code[3:2] == 2'b00)); // R6
  AST_LEFT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !l_drive |-> l_data == '0); // R7
  AST_RIGHT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !r_drive |-> r_data == '0); // R7
  AST_DEBUG_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_data == file_view[dbg_idx]); // R9
endmodule

bind dcode_regfile rfd_checker #(.DW(DW), .NREG(NREG)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .exec_phase (exec_phase),
  .a_code     (a_code),
  .b_code     (b_code),
  .t_code     (t_code),
  .wr_data    (wr_data),
  .l_data     (l_data),
  .l_drive    (l_drive),
  .r_data     (r_data),
  .r_drive    (r_drive),
  .dbg_idx    (dbg_idx),
  .dbg_data   (dbg_data),
  .file_view  (file_view)
);

// File: tb/sim_dcode_regfile.sv
`timescale 1ns/1ps
module sim_dcode_regfile;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       exec_phase = 1'b0;
  logic [2:0] a_code = '0;
  logic [3:0] b_code = '0;
  logic [4:0] t_code = 5'd31;
  logic [7:0] wr_data = '0;
  logic [7:0] l_data, r_data, dbg_data;
  logic       l_drive, r_drive;
  logic [1:0] dbg_idx = '0;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [7:0] model [4];

  dcode_regfile u0 (
    .clk(clk), .rst_n(rst_n), .exec_phase(exec_phase),
    .a_code(a_code), .b_code(b_code), .t_code(t_code), .wr_data(wr_data),
    .l_data(l_data), .l_drive(l_drive), .r_data(r_data), .r_drive(r_drive),
    .dbg_idx(dbg_idx), .dbg_data(dbg_data)
  );

  always #5 clk = ~clk;

  // Expected-value functions, restated from the requirements
  function automatic bit left_on(input logic [2:0] c);  return c < 3'd4; endfunction
  function automatic bit right_on(input logic [3:0] c); return c < 4'd4; endfunction
  function automatic bit writes(input logic e, input logic [4:0] t); return e && (t <= 5'd3); endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_ports(input string tagl, input string tagr);
    logic [7:0] el, er;
    el = left_on(a_code) ? model[a_code[1:0]] : 8'h00;
    er = right_on(b_code) ? model[b_code[1:0]] : 8'h00;
    check(l_drive == left_on(a_code), {tagl, " left drive"}, int'(l_drive), int'(left_on(a_code)));
    check(l_data == el, {tagl, " left data"}, int'(l_data), int'(el));
    check(r_drive == right_on(b_code), {tagr, " right drive"}, int'(r_drive), int'(right_on(b_code)));
    check(r_data == er, {tagr, " right data"}, int'(r_data), int'(er));
  endtask

  task automatic check_dump(input string tag);
    for (int i = 0; i < 4; i++) begin
      dbg_idx = 2'(i);
      #1;
      check(dbg_data == model[i], tag, int'(dbg_data), int'(model[i]));
    end
  endtask

  // One cycle: drive at the falling edge, check reads before the rising edge, update model at it
  task automatic step(input logic e, input logic [2:0] a, input logic [3:0] b,
                      input logic [4:0] t, input logic [7:0] d, input string tag);
    @(negedge clk);
    exec_phase = e; a_code = a; b_code = b; t_code = t; wr_data = d;
    #2;
    check_ports((left_on(a) && writes(e, t) && a[1:0] == t[1:0]) ? "R8" : "R5",
                (right_on(b) && writes(e, t) && b[1:0] == t[1:0]) ? "R8" : "R6");
    @(posedge clk);
    if (writes(e, t)) model[t[1:0]] = d;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) model[i] = 8'h00;
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(posedge clk);
    // R1: reset state
    #1;
    check_dump("R1 reset value");
    check(l_drive == 1'b1 && l_data == 8'h00, "R1 left after reset", int'(l_data), 0);
    @(negedge clk); rst_n = 1'b1;

    // R2: fill each register
    for (int i = 0; i < 4; i++) step(1'b1, 3'd4, 4'd8, 5'(i), 8'(8'h11 * (i + 1)), "R2");
    @(negedge clk); exec_phase = 1'b0; t_code = 5'd31;
    check_dump("R2 filled");

    // R3: write attempt outside the execute phase
    step(1'b0, 3'd1, 4'd1, 5'd1, 8'hEE, "R3");
    @(negedge clk); check_dump("R3 idle phase no write");

    // R4: foreign destination codes with the execute phase on
    step(1'b1, 3'd0, 4'd0, 5'd4, 8'hA5, "R4");
    step(1'b1, 3'd0, 4'd0, 5'd8, 8'hA5, "R4");
    step(1'b1, 3'd0, 4'd0, 5'd16, 8'hA5, "R4");
    step(1'b1, 3'd0, 4'd0, 5'd31, 8'hA5, "R4");
    @(negedge clk); exec_phase = 1'b0; check_dump("R4 foreign target no write");

    // R7: disabled codes on both ports
    step(1'b0, 3'd7, 4'd4, 5'd31, 8'h00, "R7");
    step(1'b0, 3'd5, 4'd12, 5'd31, 8'h00, "R7");
    @(negedge clk); check(l_data == 8'h00 && r_data == 8'h00, "R7 released buses", int'({l_data, r_data}), 0);

    // R8: read the register being written, old then new
    step(1'b1, 3'd2, 4'd2, 5'd2, 8'h5C, "R8");
    @(negedge clk); exec_phase = 1'b0; t_code = 5'd31; #2;
    check(l_data == 8'h5C, "R8 left new value after edge", int'(l_data), 8'h5C);
    check(r_data == 8'h5C, "R8 right new value after edge", int'(r_data), 8'h5C);

    // Random mix, biased toward register codes and the execute phase
    for (int n = 0; n < 400; n++) begin
      logic [4:0] t;
      t = ($urandom_range(0, 9) < 6) ? 5'($urandom_range(0, 3)) : 5'($urandom_range(0, 31));
      step(($urandom_range(0, 3) != 0), 3'($urandom_range(0, 7)), 4'($urandom_range(0, 15)),
           t, 8'($urandom_range(0, 255)), "R2");
    end
    @(negedge clk); exec_phase = 1'b0; t_code = 5'd31;
    check_dump("R9 debug view after random");

    // R1: reset clears written state
    rst_n = 1'b0;
    for (int i = 0; i < 4; i++) model[i] = 8'h00;
    #2;
    check_dump("R1 reset clears");
    @(negedge clk); rst_n = 1'b1;

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule